// File: doc/BRIEF.md
# Token-Ring Node Command Decoder

This block sits between a host processor and the network engine of a token-passing node controller. The host writes single command bytes. The block decodes each byte and maintains the transmitter and receiver status flags. It also holds the pending transmit and receive requests, the buffer page selections, the broadcast-accept flag and the packet-length mode. The network engine reports progress through one-cycle event pulses: token arrival, start of reception, end of reception, end of transmission and acknowledge received. The block turns the selected page and the half-page offset into buffer start addresses for the engine.

Disabling the transmitter or the receiver is lazy. A request that has not started yet is dropped at once, but the flag that reports the idle state only rises when the next token arrives. A reception already in progress always runs to its end.

Events in a cycle are applied first. A command written in the same cycle then acts on the state those events leave.

Top module: `tnd_cmd_decoder`

## Requirements
- R1: After reset, tx_avail=1 and rx_inhibit=1. tx_acked, tx_irq, both pending flags, both busy flags, bcast_en and long_pkt_en are 0. Both base addresses are 0.
- R2: Only these command bytes are recognised: 0x00 (clear transmit interrupt), 0x01 (disable transmitter), 0x02 (disable receiver), b0fnn100 (enable receive), 00fnn011 (enable transmit) and 0000c101 (configure). Any other byte changes no output.
- R3: When no transmission is busy, enable transmit clears tx_avail and tx_acked, sets tx_pending and latches page nn and offset bit f. While a transmission is busy, the command is ignored.
- R4: A token that arrives while tx_pending=1 clears tx_pending and sets tx_busy. While busy, an ack pulse sets tx_acked. A tx-done pulse clears tx_busy and sets both tx_avail and tx_irq.
- R5: Disable transmitter drops an unstarted pending transmit at once, with tx_avail unchanged. tx_avail and tx_irq are then set at the next token. The command has no effect while a transmission is busy.
- R6: Command 0x00 clears tx_irq only and leaves tx_avail and tx_acked unchanged. If tx_irq is being set in the same cycle, the set wins.
- R7: When no reception is busy, enable receive clears rx_inhibit, sets rx_pending, sets bcast_en to bit 7 (b) and latches page nn and offset bit f. While a reception is busy, the command is ignored.
- R8: An rx-start pulse while rx_pending=1 clears rx_pending and sets rx_busy. An rx-done pulse while busy clears rx_busy and sets rx_inhibit.
- R9: Disable receiver drops an unstarted pending receive, and rx_inhibit is set at the next token. During a busy reception the command has no effect, and the reception completes normally.
- R10: Configure sets long_pkt_en to bit 3 (c).
- R11: Each base address equals nn*512 + f*256, where nn is bits 4:3 and f is bit 5 of the enabling command.
- R12: Ack and tx-done pulses without a busy transmission have no effect. So do rx-start without a pending receive and rx-done without a busy reception.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_wr | input | 1 | Command write strobe |
| cmd_data | input | 8 | Command byte |
| ev_token | input | 1 | Token received pulse |
| ev_rx_start | input | 1 | Reception started pulse |
| ev_rx_done | input | 1 | Reception completed pulse |
| ev_tx_done | input | 1 | Transmission completed pulse |
| ev_ack | input | 1 | Acknowledge received pulse |
| tx_avail | output | 1 | Transmitter available flag |
| tx_acked | output | 1 | Transmitted message acknowledged flag |
| tx_irq | output | 1 | Latched transmit interrupt |
| tx_pending | output | 1 | Transmit armed, waiting for token |
| tx_busy | output | 1 | Transmission in progress |
| rx_inhibit | output | 1 | Receiver inhibited flag |
| rx_pending | output | 1 | Receive armed, waiting for a packet |
| rx_busy | output | 1 | Reception in progress |
| bcast_en | output | 1 | Broadcast packets accepted |
| long_pkt_en | output | 1 | Long packets allowed |
| tx_base_addr | output | RAM_ADDR_W | Transmit buffer start address |
| rx_base_addr | output | RAM_ADDR_W | Receive buffer start address |

## Verification
All 256 command byte values are written from the reset state, and the full output state is compared with a value computed arithmetically from the byte. This sweep separates the six recognised encodings from every near miss, such as a wrong low-bit code or a set bit 6 on an enable-transmit byte. It also shows that each page and offset combination lands on its own address. Directed sequences then separate the lazy disable paths from the immediate ones by sampling before and after the token. They also separate a busy transfer from a pending one by issuing disables and enables in each state, and they separate real completions from stray event pulses.

// File: rtl/tnd_pkg.sv
package tnd_pkg;

   typedef enum logic [2:0] {
      CK_NONE,
      CK_CLR_IRQ,
      CK_DIS_TX,
      CK_DIS_RX,
      CK_EN_RX,
      CK_EN_TX,
      CK_CFG
   } cmd_kind_e;

   typedef struct packed {
      cmd_kind_e  kind;
      logic [1:0] page;
      logic       fine;
      logic       bcast;
      logic       long_en;
   } cmd_t;

endpackage

// File: rtl/tnd_cmd_decode.sv
module tnd_cmd_decode
   import tnd_pkg::*;
(
   input  logic       wr,
   input  logic [7:0] data,
   output cmd_t       cmd
);

   logic is_en_tx;
   logic is_en_rx;
   logic is_cfg;

   assign is_en_tx = (data[7:6] == 2'b00) && (data[2:0] == 3'b011);
   assign is_en_rx = (data[6] == 1'b0)    && (data[2:0] == 3'b100);
   assign is_cfg   = (data[7:4] == 4'h0)  && (data[2:0] == 3'b101);

   always_comb begin
      cmd.page    = data[4:3];
      cmd.fine    = data[5];
      cmd.bcast   = data[7];
      cmd.long_en = data[3];
      cmd.kind    = CK_NONE;
      if (wr) begin
         if (data == 8'h00)      cmd.kind = CK_CLR_IRQ;
         else if (data == 8'h01) cmd.kind = CK_DIS_TX;
         else if (data == 8'h02) cmd.kind = CK_DIS_RX;
         else if (is_en_tx)      cmd.kind = CK_EN_TX;
         else if (is_en_rx)      cmd.kind = CK_EN_RX;
         else if (is_cfg)        cmd.kind = CK_CFG;
      end
   end

endmodule

// File: rtl/tnd_base_addr.sv
module tnd_base_addr #(
   parameter int ADDR_W  = 11,
   parameter bit FINE_EN = 1'b1
) (
   input  logic [1:0]        page,
   input  logic              fine,
   output logic [ADDR_W-1:0] addr
);

   localparam int LOW_W = ADDR_W - 3;

   generate
      if (FINE_EN) begin : g_fine
         assign addr = {page, fine, {LOW_W{1'b0}}};
      end else begin : g_coarse
         logic unused_fine;
         assign unused_fine = fine;
         assign addr = {page, 1'b0, {LOW_W{1'b0}}};
      end
   endgenerate

endmodule

// File: rtl/tnd_tx_ctrl.sv
module tnd_tx_ctrl
   import tnd_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  cmd_t       cmd,
   input  logic       tok,
   input  logic       done,
   input  logic       ack,
   output logic       avail,
   output logic       acked,
   output logic       irq,
   output logic       pending,
   output logic       busy,
   output logic [1:0] page,
   output logic       fine
);

   logic       avail_q, acked_q, irq_q, pend_q, busy_q, dis_q, fine_q;
   logic [1:0] page_q;
   logic       avail_d, acked_d, irq_d, pend_d, busy_d, dis_d, fine_d;
   logic [1:0] page_d;
   logic       irq_set;

   always_comb begin
      avail_d = avail_q;
      acked_d = acked_q;
      irq_d   = irq_q;
      pend_d  = pend_q;
      busy_d  = busy_q;
      dis_d   = dis_q;
      page_d  = page_q;
      fine_d  = fine_q;
      irq_set = 1'b0;
      // network events on current state
      if (busy_q) begin
         if (ack) acked_d = 1'b1;
         if (done) begin
            busy_d  = 1'b0;
            avail_d = 1'b1;
            irq_set = 1'b1;
         end
      end else if (tok) begin
         if (pend_q) begin
            pend_d = 1'b0;
            busy_d = 1'b1;
         end else if (dis_q) begin
            dis_d   = 1'b0;
            avail_d = 1'b1;
            irq_set = 1'b1;
         end
      end
      if (irq_set) irq_d = 1'b1;
      // host command on the resulting state
      unique case (cmd.kind)
         CK_CLR_IRQ: if (!irq_set) irq_d = 1'b0;
         CK_EN_TX: begin
            if (!busy_d) begin
               pend_d  = 1'b1;
               avail_d = 1'b0;
               acked_d = 1'b0;
               dis_d   = 1'b0;
               page_d  = cmd.page;
               fine_d  = cmd.fine;
            end
         end
         CK_DIS_TX: begin
            if (!busy_d) begin
               pend_d = 1'b0;
               dis_d  = 1'b1;
            end
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         avail_q <= 1'b1;
         acked_q <= 1'b0;
         irq_q   <= 1'b0;
         pend_q  <= 1'b0;
         busy_q  <= 1'b0;
         dis_q   <= 1'b0;
         page_q  <= 2'd0;
         fine_q  <= 1'b0;
      end else begin
         avail_q <= avail_d;
         acked_q <= acked_d;
         irq_q   <= irq_d;
         pend_q  <= pend_d;
         busy_q  <= busy_d;
         dis_q   <= dis_d;
         page_q  <= page_d;
         fine_q  <= fine_d;
      end
   end

   assign avail   = avail_q;
   assign acked   = acked_q;
   assign irq     = irq_q;
   assign pending = pend_q;
   assign busy    = busy_q;
   assign page    = page_q;
   assign fine    = fine_q;

endmodule

// File: rtl/tnd_rx_ctrl.sv
module tnd_rx_ctrl
   import tnd_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  cmd_t       cmd,
   input  logic       tok,
   input  logic       start,
   input  logic       done,
   output logic       inhibit,
   output logic       pending,
   output logic       busy,
   output logic       bcast,
   output logic [1:0] page,
   output logic       fine
);

   logic       inh_q, pend_q, busy_q, dis_q, bc_q, fine_q;
   logic [1:0] page_q;
   logic       inh_d, pend_d, busy_d, dis_d, bc_d, fine_d;
   logic [1:0] page_d;

   always_comb begin
      inh_d  = inh_q;
      pend_d = pend_q;
      busy_d = busy_q;
      dis_d  = dis_q;
      bc_d   = bc_q;
      page_d = page_q;
      fine_d = fine_q;
      // network events on current state
      if (busy_q) begin
         if (done) begin
            busy_d = 1'b0;
            inh_d  = 1'b1;
         end
      end else if (pend_q && start) begin
         pend_d = 1'b0;
         busy_d = 1'b1;
      end
      if (tok && dis_q && !busy_q) begin
         dis_d = 1'b0;
         inh_d = 1'b1;
      end
      // host command on the resulting state
      unique case (cmd.kind)
         CK_EN_RX: begin
            if (!busy_d) begin
               inh_d  = 1'b0;
               pend_d = 1'b1;
               dis_d  = 1'b0;
               bc_d   = cmd.bcast;
               page_d = cmd.page;
               fine_d = cmd.fine;
            end
         end
         CK_DIS_RX: begin
            if (!busy_d) begin
               pend_d = 1'b0;
               dis_d  = 1'b1;
            end
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         inh_q  <= 1'b1;
         pend_q <= 1'b0;
         busy_q <= 1'b0;
         dis_q  <= 1'b0;
         bc_q   <= 1'b0;
         page_q <= 2'd0;
         fine_q <= 1'b0;
      end else begin
         inh_q  <= inh_d;
         pend_q <= pend_d;
         busy_q <= busy_d;
         dis_q  <= dis_d;
         bc_q   <= bc_d;
         page_q <= page_d;
         fine_q <= fine_d;
      end
   end

   assign inhibit = inh_q;
   assign pending = pend_q;
   assign busy    = busy_q;
   assign bcast   = bc_q;
   assign page    = page_q;
   assign fine    = fine_q;

endmodule

// File: rtl/tnd_cmd_decoder.sv
module tnd_cmd_decoder
   import tnd_pkg::*;
#(
   parameter int RAM_ADDR_W = 11,
   parameter bit FINE_EN    = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  cmd_wr,
   input  logic [7:0]            cmd_data,
   input  logic                  ev_token,
   input  logic                  ev_rx_start,
   input  logic                  ev_rx_done,
   input  logic                  ev_tx_done,
   input  logic                  ev_ack,
   output logic                  tx_avail,
   output logic                  tx_acked,
   output logic                  tx_irq,
   output logic                  tx_pending,
   output logic                  tx_busy,
   output logic                  rx_inhibit,
   output logic                  rx_pending,
   output logic                  rx_busy,
   output logic                  bcast_en,
   output logic                  long_pkt_en,
   output logic [RAM_ADDR_W-1:0] tx_base_addr,
   output logic [RAM_ADDR_W-1:0] rx_base_addr
);

   localparam int PAGE_BITS = 2;
   localparam int MIN_ADDR_W = PAGE_BITS + 2;

   generate
      if (RAM_ADDR_W < MIN_ADDR_W) begin : g_bad_width
         $error("RAM_ADDR_W too small for page plus offset fields");
      end
   endgenerate

   cmd_t             cmd;
   logic [1:0]       tx_page, rx_page;
   logic             tx_fine, rx_fine;
   logic             long_q;

   tnd_cmd_decode u_dec (
      .wr   (cmd_wr),
      .data (cmd_data),
      .cmd  (cmd)
   );

   tnd_tx_ctrl u_tx (
      .clk     (clk),
      .rst_n   (rst_n),
      .cmd     (cmd),
      .tok     (ev_token),
      .done    (ev_tx_done),
      .ack     (ev_ack),
      .avail   (tx_avail),
      .acked   (tx_acked),
      .irq     (tx_irq),
      .pending (tx_pending),
      .busy    (tx_busy),
      .page    (tx_page),
      .fine    (tx_fine)
   );

   tnd_rx_ctrl u_rx (
      .clk     (clk),
      .rst_n   (rst_n),
      .cmd     (cmd),
      .tok     (ev_token),
      .start   (ev_rx_start),
      .done    (ev_rx_done),
      .inhibit (rx_inhibit),
      .pending (rx_pending),
      .busy    (rx_busy),
      .bcast   (bcast_en),
      .page    (rx_page),
      .fine    (rx_fine)
   );

   tnd_base_addr #(.ADDR_W(RAM_ADDR_W), .FINE_EN(FINE_EN)) u_tx_addr (
      .page (tx_page),
      .fine (tx_fine),
      .addr (tx_base_addr)
   );

   tnd_base_addr #(.ADDR_W(RAM_ADDR_W), .FINE_EN(FINE_EN)) u_rx_addr (
      .page (rx_page),
      .fine (rx_fine),
      .addr (rx_base_addr)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 long_q <= 1'b0;
      else if (cmd.kind == CK_CFG) long_q <= cmd.long_en;
   end

   assign long_pkt_en = long_q;

endmodule

// File: rtl/tnd_cmd_decoder_chk.sv
module tnd_cmd_decoder_chk #(
   parameter int RAM_ADDR_W = 11,
   parameter bit FINE_EN    = 1'b1
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  cmd_wr,
   input logic [7:0]            cmd_data,
   input logic                  ev_token,
   input logic                  ev_rx_start,
   input logic                  ev_rx_done,
   input logic                  ev_tx_done,
   input logic                  ev_ack,
   input logic                  tx_avail,
   input logic                  tx_acked,
   input logic                  tx_irq,
   input logic                  tx_pending,
   input logic                  tx_busy,
   input logic                  rx_inhibit,
   input logic                  rx_pending,
   input logic                  rx_busy,
   input logic                  bcast_en,
   input logic                  long_pkt_en,
   input logic [RAM_ADDR_W-1:0] tx_base_addr,
   input logic [RAM_ADDR_W-1:0] rx_base_addr
);

   logic                  c_en_tx, c_en_rx, c_cfg, c_known, no_ev;
   logic [RAM_ADDR_W-1:0] c_addr;

   assign c_en_tx = cmd_wr && cmd_data[7:6] == 2'b00 && cmd_data[2:0] == 3'b011;
   assign c_en_rx = cmd_wr && !cmd_data[6] && cmd_data[2:0] == 3'b100;
   assign c_cfg   = cmd_wr && cmd_data[7:4] == 4'h0 && cmd_data[2:0] == 3'b101;
   assign c_known = c_en_tx || c_en_rx || c_cfg || cmd_data <= 8'h02;
   assign no_ev   = !(ev_token || ev_rx_start || ev_rx_done || ev_tx_done || ev_ack);
   assign c_addr  = RAM_ADDR_W'(cmd_data[4:3]) * RAM_ADDR_W'(1 << (RAM_ADDR_W - 2))
                  + ((cmd_data[5] && FINE_EN) ? RAM_ADDR_W'(1 << (RAM_ADDR_W - 3)) : '0);

   AST_TX_ARM: assert property (@(posedge clk) disable iff (!rst_n)
      c_en_tx && !tx_busy && !(ev_token && tx_pending)
      |=> tx_pending && !tx_avail && !tx_acked && tx_base_addr == $past(c_addr)); // R3

   AST_TX_START: assert property (@(posedge clk) disable iff (!rst_n)
      ev_token && tx_pending && !tx_busy |=> tx_busy && !tx_pending); // R4

   AST_TA_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tx_avail) |-> tx_irq); // R4

   AST_TMA_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !tx_busy && !tx_acked |=> !tx_acked); // R12

   AST_RX_ARM: assert property (@(posedge clk) disable iff (!rst_n)
      c_en_rx && !rx_busy && !(rx_pending && ev_rx_start)
      |=> !rx_inhibit && rx_pending && bcast_en == $past(cmd_data[7])
          && rx_base_addr == $past(c_addr)); // R7

   AST_RX_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      rx_busy && ev_rx_done && !c_en_rx |=> rx_inhibit && !rx_busy); // R8

   AST_RX_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      rx_busy && !ev_rx_done |=> rx_busy); // R9

   AST_PEND_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(tx_pending && tx_busy) && !(rx_pending && rx_busy)); // R8

   AST_CFG: assert property (@(posedge clk) disable iff (!rst_n)
      c_cfg |=> long_pkt_en == $past(cmd_data[3])); // R10

   AST_BAD_CMD: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_wr && !c_known && no_ev
      |=> $stable({tx_avail, tx_acked, tx_irq, tx_pending, tx_busy, rx_inhibit,
                   rx_pending, rx_busy, bcast_en, long_pkt_en,
                   tx_base_addr, rx_base_addr})); // R2

endmodule

bind tnd_cmd_decoder tnd_cmd_decoder_chk #(
   .RAM_ADDR_W (RAM_ADDR_W),
   .FINE_EN    (FINE_EN)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .cmd_wr       (cmd_wr),
   .cmd_data     (cmd_data),
   .ev_token     (ev_token),
   .ev_rx_start  (ev_rx_start),
   .ev_rx_done   (ev_rx_done),
   .ev_tx_done   (ev_tx_done),
   .ev_ack       (ev_ack),
   .tx_avail     (tx_avail),
   .tx_acked     (tx_acked),
   .tx_irq       (tx_irq),
   .tx_pending   (tx_pending),
   .tx_busy      (tx_busy),
   .rx_inhibit   (rx_inhibit),
   .rx_pending   (rx_pending),
   .rx_busy      (rx_busy),
   .bcast_en     (bcast_en),
   .long_pkt_en  (long_pkt_en),
   .tx_base_addr (tx_base_addr),
   .rx_base_addr (rx_base_addr)
);

// File: tb/tnd_cmd_decoder_bench.sv
module tnd_cmd_decoder_bench;

   localparam int AW = 11;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cmd_wr = 1'b0;
   logic [7:0]    cmd_data = 8'h00;
   logic          ev_token = 1'b0, ev_rx_start = 1'b0, ev_rx_done = 1'b0;
   logic          ev_tx_done = 1'b0, ev_ack = 1'b0;
   logic          tx_avail, tx_acked, tx_irq, tx_pending, tx_busy;
   logic          rx_inhibit, rx_pending, rx_busy, bcast_en, long_pkt_en;
   logic [AW-1:0] tx_base_addr, rx_base_addr;

   int  checks = 0;
   int  errors = 0;
   bit  done_flag = 1'b0;

   always #5 clk = ~clk;

   tnd_cmd_decoder #(.RAM_ADDR_W(AW), .FINE_EN(1'b1)) u_tnd_cmd_decoder (
      .clk          (clk),
      .rst_n        (rst_n),
      .cmd_wr       (cmd_wr),
      .cmd_data     (cmd_data),
      .ev_token     (ev_token),
      .ev_rx_start  (ev_rx_start),
      .ev_rx_done   (ev_rx_done),
      .ev_tx_done   (ev_tx_done),
      .ev_ack       (ev_ack),
      .tx_avail     (tx_avail),
      .tx_acked     (tx_acked),
      .tx_irq       (tx_irq),
      .tx_pending   (tx_pending),
      .tx_busy      (tx_busy),
      .rx_inhibit   (rx_inhibit),
      .rx_pending   (rx_pending),
      .rx_busy      (rx_busy),
      .bcast_en     (bcast_en),
      .long_pkt_en  (long_pkt_en),
      .tx_base_addr (tx_base_addr),
      .rx_base_addr (rx_base_addr)
   );

   function automatic logic [31:0] observed();
      return {tx_avail, tx_acked, rx_inhibit, tx_irq, tx_pending, rx_pending,
              tx_busy, rx_busy, bcast_en, long_pkt_en, tx_base_addr, rx_base_addr};
   endfunction

   function automatic logic [AW-1:0] addr_of(input logic [7:0] c);
      return AW'(int'(c[4:3]) * 512 + int'(c[5]) * 256);
   endfunction

   // expected state after one command written from reset
   function automatic logic [31:0] model(input logic [7:0] c);
      logic ta = 1, tma = 0, ri = 1, irq = 0, txp = 0, rxp = 0, bc = 0, lg = 0;
      logic [AW-1:0] txa = '0, rxa = '0;
      if (c[7:6] == 2'b00 && c[2:0] == 3'b011) begin
         ta = 0; tma = 0; txp = 1; txa = addr_of(c);
      end else if (!c[6] && c[2:0] == 3'b100) begin
         ri = 0; rxp = 1; bc = c[7]; rxa = addr_of(c);
      end else if (c[7:4] == 4'h0 && c[2:0] == 3'b101) begin
         lg = c[3];
      end
      return {ta, tma, ri, irq, txp, rxp, 1'b0, 1'b0, bc, lg, txa, rxa};
   endfunction

   task automatic chk(input string tag, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic cmd(input logic [7:0] c);
      @(negedge clk);
      cmd_wr = 1'b1;
      cmd_data = c;
      @(negedge clk);
      cmd_wr = 1'b0;
   endtask

   // v = {ack, tx_done, rx_done, rx_start, token}
   task automatic ev(input logic [4:0] v);
      @(negedge clk);
      {ev_ack, ev_tx_done, ev_rx_done, ev_rx_start, ev_token} = v;
      @(negedge clk);
      {ev_ack, ev_tx_done, ev_rx_done, ev_rx_start, ev_token} = 5'b0;
   endtask

   localparam logic [4:0] TOK = 5'b00001, RXS = 5'b00010, RXD = 5'b00100,
                          TXD = 5'b01000, ACK = 5'b10000;

   task automatic finish_run();
      if (!done_flag) begin
         done_flag = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      do_reset();
      chk("R1", "reset state", observed(), model(8'hFF));

      // R2 R3 R7 R10 R11: sweep of every command byte from reset
      for (int i = 0; i < 256; i++) begin
         do_reset();
         cmd(8'(i));
         chk("R2", $sformatf("byte 0x%02h", i), observed(), model(8'(i)));
      end

      // R4 transmit with ack, then R6 clear interrupt
      do_reset();
      cmd(8'h1B);
      chk("R3", "armed tx_pending", 32'(tx_pending), 32'd1);
      chk("R11", "tx addr page3", 32'(tx_base_addr), 32'd1536);
      ev(TOK);
      chk("R4", "busy/pending after token", 32'({tx_busy, tx_pending}), 32'b10);
      ev(ACK);
      chk("R4", "acked", 32'(tx_acked), 32'd1);
      chk("R4", "avail still low", 32'(tx_avail), 32'd0);
      ev(TXD);
      chk("R4", "done avail/busy/irq", 32'({tx_avail, tx_busy, tx_irq}), 32'b101);
      cmd(8'h00);
      chk("R6", "irq clear keeps flags", 32'({tx_irq, tx_avail, tx_acked}), 32'b011);

      // R4 without ack, fine offset
      cmd(8'h2B);
      chk("R3", "enable clears acked", 32'({tx_avail, tx_acked}), 32'b00);
      chk("R11", "tx addr page1 fine", 32'(tx_base_addr), 32'd768);
      ev(TOK);
      ev(TXD);
      chk("R4", "no ack done", 32'({tx_avail, tx_acked}), 32'b10);

      // R12 stray events
      do_reset();
      ev(ACK | TXD);
      chk("R12", "stray tx events", 32'({tx_avail, tx_acked, tx_irq, tx_busy}), 32'b1000);
      ev(RXS);
      ev(RXD);
      chk("R12", "stray rx events", 32'({rx_inhibit, rx_busy, rx_pending}), 32'b100);

      // R5 lazy transmitter disable
      cmd(8'h03);
      cmd(8'h01);
      chk("R5", "pending dropped, avail waits", 32'({tx_pending, tx_avail}), 32'b00);
      ev(TOK);
      chk("R5", "token sets avail", 32'({tx_avail, tx_busy, tx_irq}), 32'b101);

      // R5 disable while busy, R3 enable while busy
      do_reset();
      cmd(8'h03);
      ev(TOK);
      cmd(8'h01);
      chk("R5", "busy unaffected", 32'({tx_busy, tx_avail}), 32'b10);
      cmd(8'h1B);
      chk("R3", "enable ignored when busy", 32'({tx_pending, 21'(tx_base_addr)}), 32'd0);
      ev(TXD);
      chk("R5", "done after disable", 32'(tx_avail), 32'd1);

      // R7 R8 receive flow
      do_reset();
      cmd(8'h8C);
      chk("R7", "rx armed", 32'({rx_inhibit, rx_pending, bcast_en}), 32'b011);
      chk("R11", "rx addr page1", 32'(rx_base_addr), 32'd512);
      ev(RXS);
      chk("R8", "rx busy", 32'({rx_busy, rx_pending}), 32'b10);
      cmd(8'h34);
      chk("R7", "enable ignored when busy", 32'({rx_pending, 21'(rx_base_addr)}), 32'd512);
      ev(RXD);
      chk("R8", "rx done", 32'({rx_inhibit, rx_busy}), 32'b10);

      // R9 lazy receiver disable
      cmd(8'h04);
      cmd(8'h02);
      chk("R9", "rx pending dropped, inhibit waits", 32'({rx_pending, rx_inhibit}), 32'b00);
      ev(TOK);
      chk("R9", "token sets inhibit", 32'(rx_inhibit), 32'd1);

      // R9 disable during reception
      cmd(8'h24);
      ev(RXS);
      cmd(8'h02);
      ev(TOK);
      chk("R9", "reception continues", 32'({rx_busy, rx_inhibit}), 32'b10);
      ev(RXD);
      chk("R9", "reception completes", 32'({rx_busy, rx_inhibit}), 32'b01);

      // R10 configuration toggling
      cmd(8'h0D);
      chk("R10", "long on", 32'(long_pkt_en), 32'd1);
      cmd(8'h05);
      chk("R10", "long off", 32'(long_pkt_en), 32'd0);

      finish_run();
   end

endmodule